// File: doc/BRIEF.md
# Region-Steered Data Address Translator

This block translates data virtual page numbers into physical page numbers for the load/store path. Each lookup address is first classed into one of three program regions: stack, global static data, or heap. The class comes from a comparison against three boundary addresses that software writes through a small register port. Stack and global lookups are searched in a small fully associative micro-TLB owned by that region. Only the micro-TLB of the addressed region is enabled. Heap lookups skip the first level.

A shared, larger fully associative second-level TLB holds translations for all regions. It answers heap lookups and any micro-TLB miss. When a stack or global lookup misses its micro-TLB and hits the second level, the returned translation is copied into that region's micro-TLB. A lookup that misses both levels raises a miss flag, so an external walker can refill the second level through the refill port. Each response also carries the region tag and a one-hot select for the matching first-level data cachelet.

Top module: `region_dtlb`

## Requirements
- R1: Region decode on the full virtual address. The address is stack when the stack-low boundary is non-zero and the address is at or above it. Otherwise it is global when global-low <= address < global-high. Any other address is heap. A stack-low of zero disables the stack region.
- R2: The region tag encodes stack = 0, global = 1 and heap = 2. The cachelet select is one-hot: bit 0 is stack, bit 1 is global and bit 2 is heap.
- R3: After reset, rsp_valid_o, rsp_hit_o and rsp_miss_o are 0. All three boundary registers reset to 0, so every address decodes as heap.
- R4: A lookup presented with req_valid_i in one cycle produces its response, with rsp_valid_o high, in the next cycle. rsp_valid_o is low in any cycle that follows a cycle without a request.
- R5: A heap lookup never reports a first-level hit. It is answered by the second-level TLB alone.
- R6: A stack or global lookup that misses its micro-TLB and hits the second level returns the second-level page with rsp_utlb_hit_o = 0. It also installs that translation in the region's micro-TLB, so a later lookup of the same page reports rsp_utlb_hit_o = 1.
- R7: Each micro-TLB has 4 entries, filled round-robin from entry 0 after reset or invalidation. The fifth distinct page installed evicts the first.
- R8: A lookup that misses both levels gives rsp_hit_o = 0, rsp_miss_o = 1 and rsp_ppn_o = 0. It installs nothing in a micro-TLB.
- R9: A refill whose page number is already present in the 32-entry second-level TLB overwrites that entry in place. Any other refill is written at a round-robin pointer that starts at entry 0 and advances only on such writes.
- R10: A write to any of the three boundary registers invalidates every entry of both micro-TLBs. A lookup issued after the write therefore misses the first level.
- R11: The boundary write selector is 0 for stack-low, 1 for global-low and 2 for global-high. A write with selector 3 is ignored: it changes no boundary and invalidates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | VA_W | Lookup virtual address |
| bnd_we_i | input | 1 | Boundary register write strobe |
| bnd_sel_i | input | 2 | Boundary register selector |
| bnd_data_i | input | VA_W | Boundary address to write |
| fill_valid_i | input | 1 | Second-level refill strobe |
| fill_vpn_i | input | VPN_W | Refill virtual page number |
| fill_ppn_i | input | PPN_W | Refill physical page number |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Translation found at either level |
| rsp_miss_o | output | 1 | Translation missing at both levels |
| rsp_utlb_hit_o | output | 1 | Translation came from a region micro-TLB |
| rsp_ppn_o | output | PPN_W | Physical page number, 0 on a miss |
| rsp_region_o | output | 2 | Region tag |
| rsp_cache_sel_o | output | 3 | One-hot cachelet select |

## Verification
Directed lookups sit exactly on each boundary and one address below it. These separate the inclusive and exclusive edges of the decode rule, and a zero stack boundary shows that the stack region is disabled. Repeated lookups to one page separate a first-level hit from a second-level hit. Five distinct stack pages expose the round-robin victim. Thirty-three heap refills followed by an in-place overwrite show the second-level replacement pointer and that it does not advance on a matching refill. Random lookups drawn from small page pools in all three regions are mixed with refills and boundary rewrites. This mix exercises refill-on-miss, invalidation and the region-to-cachelet mapping together against a bench model of both levels.

// File: rtl/region_dtlb_pkg.sv
package region_dtlb_pkg;
  typedef enum logic [1:0] {
    RGN_STACK  = 2'd0,
    RGN_GLOBAL = 2'd1,
    RGN_HEAP   = 2'd2
  } region_e;

  localparam int unsigned NUM_UTLB = 2;

  localparam logic [1:0] BND_STACK_LO = 2'd0;
  localparam logic [1:0] BND_GLOB_LO  = 2'd1;
  localparam logic [1:0] BND_GLOB_HI  = 2'd2;
endpackage

// File: rtl/region_decoder.sv
module region_decoder
  import region_dtlb_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bnd_we_i,
  input  logic [1:0]      bnd_sel_i,
  input  logic [VA_W-1:0] bnd_data_i,
  input  logic [VA_W-1:0] vaddr_i,
  output region_e         region_o,
  output logic            flush_o
);
  logic [VA_W-1:0] stack_lo_q, glob_lo_q, glob_hi_q;
  logic            sel_ok;

  assign sel_ok  = (bnd_sel_i == BND_STACK_LO) || (bnd_sel_i == BND_GLOB_LO) ||
                   (bnd_sel_i == BND_GLOB_HI);
  assign flush_o = bnd_we_i && sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stack_lo_q <= '0;
      glob_lo_q  <= '0;
      glob_hi_q  <= '0;
    end else if (bnd_we_i) begin
      case (bnd_sel_i)
        BND_STACK_LO: stack_lo_q <= bnd_data_i;
        BND_GLOB_LO:  glob_lo_q  <= bnd_data_i;
        BND_GLOB_HI:  glob_hi_q  <= bnd_data_i;
        default: ;
      endcase
    end
  end

  // stack wins over global when ranges overlap
  always_comb begin
    if ((stack_lo_q != '0) && (vaddr_i >= stack_lo_q))
      region_o = RGN_STACK;
    else if ((vaddr_i >= glob_lo_q) && (vaddr_i < glob_hi_q))
      region_o = RGN_GLOBAL;
    else
      region_o = RGN_HEAP;
  end
endmodule

// File: rtl/cam_tlb.sv
module cam_tlb #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_en_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             flush_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q, wr_idx;
  logic [ENTRIES-1:0] lk_match, wr_match;
  logic               wr_new;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);
    assign wr_match[g] = vld_q[g] && (vpn_q[g] == wr_vpn_i);
  end

  assign lk_hit_o = lk_en_i && (|lk_match);

  always_comb begin
    lk_ppn_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_ppn_o = lk_ppn_o | ppn_q[i];
  end

  always_comb begin
    wr_idx = ptr_q;
    wr_new = 1'b1;
    for (int i = 0; i < ENTRIES; i++)
      if (wr_match[i]) begin
        wr_idx = IDX_W'(i);
        wr_new = 1'b0;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx] <= 1'b1;
      if (wr_new) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) begin
      vpn_q[wr_idx] <= wr_vpn_i;
      ppn_q[wr_idx] <= wr_ppn_i;
    end
  end
endmodule

// File: rtl/region_dtlb.sv
module region_dtlb
  import region_dtlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_W    = 12,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned UTLB_ENTR = 4,
  parameter int unsigned L2_ENTR   = 32,
  localparam int unsigned VPN_W    = VA_W - PAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             bnd_we_i,
  input  logic [1:0]       bnd_sel_i,
  input  logic [VA_W-1:0]  bnd_data_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_utlb_hit_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic [1:0]       rsp_region_o,
  output logic [2:0]       rsp_cache_sel_o
);
  region_e           region;
  logic              flush;
  logic [VPN_W-1:0]  req_vpn;
  logic [NUM_UTLB-1:0] u_en, u_hit, u_wr;
  logic [PPN_W-1:0]  u_ppn [NUM_UTLB];
  logic              l2_hit;
  logic [PPN_W-1:0]  l2_ppn;
  logic              l1_hit, any_hit;
  logic [PPN_W-1:0]  sel_ppn;

  assign req_vpn = req_vaddr_i[VA_W-1:PAGE_W];

  region_decoder #(.VA_W(VA_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bnd_we_i   (bnd_we_i),
    .bnd_sel_i  (bnd_sel_i),
    .bnd_data_i (bnd_data_i),
    .vaddr_i    (req_vaddr_i),
    .region_o   (region),
    .flush_o    (flush)
  );

  // one micro-TLB per non-heap region; index equals region code
  for (genvar r = 0; r < NUM_UTLB; r++) begin : g_utlb
    assign u_en[r] = req_valid_i && (region == region_e'(r));
    assign u_wr[r] = u_en[r] && !u_hit[r] && l2_hit && !flush;

    cam_tlb #(.ENTRIES(UTLB_ENTR), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lk_en_i  (u_en[r]),
      .lk_vpn_i (req_vpn),
      .lk_hit_o (u_hit[r]),
      .lk_ppn_o (u_ppn[r]),
      .wr_en_i  (u_wr[r]),
      .wr_vpn_i (req_vpn),
      .wr_ppn_i (l2_ppn),
      .flush_i  (flush)
    );
  end

  cam_tlb #(.ENTRIES(L2_ENTR), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_en_i  (req_valid_i),
    .lk_vpn_i (req_vpn),
    .lk_hit_o (l2_hit),
    .lk_ppn_o (l2_ppn),
    .wr_en_i  (fill_valid_i),
    .wr_vpn_i (fill_vpn_i),
    .wr_ppn_i (fill_ppn_i),
    .flush_i  (1'b0)
  );

  always_comb begin
    l1_hit  = |u_hit;
    any_hit = l1_hit || l2_hit;
    sel_ppn = '0;
    for (int r = 0; r < NUM_UTLB; r++)
      if (u_hit[r]) sel_ppn = u_ppn[r];
    if (!l1_hit && l2_hit) sel_ppn = l2_ppn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_hit_o       <= 1'b0;
      rsp_miss_o      <= 1'b0;
      rsp_utlb_hit_o  <= 1'b0;
      rsp_ppn_o       <= '0;
      rsp_region_o    <= RGN_HEAP;
      rsp_cache_sel_o <= 3'b000;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_hit_o      <= req_valid_i && any_hit;
      rsp_miss_o     <= req_valid_i && !any_hit;
      rsp_utlb_hit_o <= req_valid_i && l1_hit;
      rsp_ppn_o      <= sel_ppn;
      if (req_valid_i) begin
        rsp_region_o    <= region;
        rsp_cache_sel_o <= 3'b001 << region;
      end
    end
  end
endmodule

// File: rtl/region_dtlb_checker.sv
module region_dtlb_checker #(
  parameter int unsigned PPN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             bnd_we_i,
  input logic [1:0]       bnd_sel_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             rsp_utlb_hit_o,
  input logic [PPN_W-1:0] rsp_ppn_o,
  input logic [1:0]       rsp_region_o,
  input logic [2:0]       rsp_cache_sel_o
);
  p_rsp_follows_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_no_rsp_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_idle_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_miss_o && !rsp_utlb_hit_o));

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($onehot0(rsp_cache_sel_o) && rsp_cache_sel_o != 3'b000 &&
                     rsp_region_o != 2'd3));

  p_heap_no_l1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cache_sel_o[2]) |-> !rsp_utlb_hit_o);

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (!rsp_hit_o && rsp_ppn_o == '0 && !rsp_utlb_hit_o));

  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bnd_we_i && bnd_sel_i != 2'd3, 2) |-> !rsp_utlb_hit_o);
endmodule

bind region_dtlb region_dtlb_checker #(.PPN_W(PPN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .bnd_we_i        (bnd_we_i),
  .bnd_sel_i       (bnd_sel_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_hit_o       (rsp_hit_o),
  .rsp_miss_o      (rsp_miss_o),
  .rsp_utlb_hit_o  (rsp_utlb_hit_o),
  .rsp_ppn_o       (rsp_ppn_o),
  .rsp_region_o    (rsp_region_o),
  .rsp_cache_sel_o (rsp_cache_sel_o)
);

// File: tb/region_dtlb_test.sv
`timescale 1ns/1ps
module region_dtlb_test;
  localparam int VA_W = 32, PAGE_W = 12, PPN_W = 20, VPN_W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic bnd_we = 1'b0;
  logic [1:0] bnd_sel = '0;
  logic [VA_W-1:0] bnd_data = '0;
  logic fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_uhit;
  logic [PPN_W-1:0] rsp_ppn;
  logic [1:0] rsp_region;
  logic [2:0] rsp_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  region_dtlb uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .bnd_we_i(bnd_we), .bnd_sel_i(bnd_sel), .bnd_data_i(bnd_data),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_utlb_hit_o(rsp_uhit), .rsp_ppn_o(rsp_ppn),
    .rsp_region_o(rsp_region), .rsp_cache_sel_o(rsp_sel)
  );

  // bench model
  logic [VA_W-1:0]  m_stack_lo = '0, m_glob_lo = '0, m_glob_hi = '0;
  logic [VPN_W-1:0] m_l2_vpn [32];
  logic [PPN_W-1:0] m_l2_ppn [32];
  bit               m_l2_v   [32];
  int               m_l2_ptr = 0;
  logic [VPN_W-1:0] m_u_vpn [2][4];
  logic [PPN_W-1:0] m_u_ppn [2][4];
  bit               m_u_v   [2][4];
  int               m_u_ptr [2];

  function automatic logic [PPN_W-1:0] ppn_of(logic [VPN_W-1:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  function automatic int exp_region(logic [VA_W-1:0] a);
    if (m_stack_lo != 0 && a >= m_stack_lo) return 0;
    if (a >= m_glob_lo && a < m_glob_hi) return 1;
    return 2;
  endfunction

  function automatic void flush_u();
    for (int r = 0; r < 2; r++) begin
      m_u_ptr[r] = 0;
      for (int i = 0; i < 4; i++) m_u_v[r][i] = 0;
    end
  endfunction

  task automatic chk(input string tag, input bit ok, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic lk(input logic [VA_W-1:0] va, input string tag);
    int r;
    bit uh, lh;
    logic [PPN_W-1:0] p;
    logic [VPN_W-1:0] v;
    bit ok;
    v = va[VA_W-1:PAGE_W];
    r = exp_region(va);
    uh = 0; lh = 0; p = '0;
    if (r < 2)
      for (int i = 0; i < 4; i++)
        if (m_u_v[r][i] && m_u_vpn[r][i] == v) begin uh = 1; p = m_u_ppn[r][i]; end
    for (int i = 0; i < 32; i++)
      if (m_l2_v[i] && m_l2_vpn[i] == v) begin
        lh = 1;
        if (!uh) p = m_l2_ppn[i];
      end
    if (r < 2 && !uh && lh) begin
      m_u_vpn[r][m_u_ptr[r]] = v;
      m_u_ppn[r][m_u_ptr[r]] = p;
      m_u_v[r][m_u_ptr[r]]   = 1;
      m_u_ptr[r] = (m_u_ptr[r] + 1) % 4;
    end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    ok = rsp_valid && rsp_hit == (uh | lh) && rsp_miss == !(uh | lh) &&
         rsp_uhit == uh && rsp_ppn == p && rsp_region == 2'(r) &&
         rsp_sel == (3'b001 << r);
    chk(tag, ok,
        $sformatf("va=%h v%0d h%0d m%0d u%0d ppn=%h rg%0d sel=%b", va, rsp_valid,
                  rsp_hit, rsp_miss, rsp_uhit, rsp_ppn, rsp_region, rsp_sel),
        $sformatf("v1 h%0d m%0d u%0d ppn=%h rg%0d sel=%b", uh | lh, !(uh | lh),
                  uh, p, r, 3'b001 << r));
  endtask

  task automatic fill(input logic [VPN_W-1:0] v);
    int idx;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = ppn_of(v);
    @(negedge clk);
    fill_valid = 1'b0;
    idx = -1;
    for (int i = 0; i < 32; i++) if (m_l2_v[i] && m_l2_vpn[i] == v) idx = i;
    if (idx < 0) begin idx = m_l2_ptr; m_l2_ptr = (m_l2_ptr + 1) % 32; end
    m_l2_vpn[idx] = v; m_l2_ppn[idx] = ppn_of(v); m_l2_v[idx] = 1;
  endtask

  task automatic wr_bnd(input logic [1:0] s, input logic [VA_W-1:0] d);
    @(negedge clk);
    bnd_we = 1'b1; bnd_sel = s; bnd_data = d;
    @(negedge clk);
    bnd_we = 1'b0;
    case (s)
      2'd0: m_stack_lo = d;
      2'd1: m_glob_lo = d;
      2'd2: m_glob_hi = d;
      default: ;
    endcase
    if (s != 2'd3) flush_u();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_l2_v[i] = 0;
    flush_u();
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R3 reset", !rsp_valid && !rsp_hit && !rsp_miss,
        $sformatf("v%0d h%0d m%0d", rsp_valid, rsp_hit, rsp_miss), "v0 h0 m0");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle after reset", !rsp_valid && !rsp_miss,
        $sformatf("v%0d m%0d", rsp_valid, rsp_miss), "v0 m0");
    lk(32'hFFFF_F000, "R3 R1 top address heap at reset, R8 miss");
    lk(32'h0000_0000, "R3 zero address heap");

    // second-level replacement
    for (int i = 0; i < 33; i++) fill(20'h40100 + 20'(i));
    lk(32'h4010_0000, "R9 first entry evicted after 33 fills");
    lk(32'h4010_1000, "R9 second entry kept");
    fill(20'h40105);
    fill(20'h40200);
    lk(32'h4010_2000, "R9 in-place refill keeps pointer");
    lk(32'h4010_1000, "R9 victim at pointer");
    lk(32'h4020_0000, "R9 new entry hit");

    // boundaries
    wr_bnd(2'd0, 32'h8000_0000);
    wr_bnd(2'd1, 32'h1000_0000);
    wr_bnd(2'd2, 32'h2000_0000);
    lk(32'h8000_0000, "R1 R2 stack low inclusive");
    lk(32'h7FFF_FFFF, "R1 R2 below stack is heap");
    lk(32'h1000_0000, "R1 R2 global low inclusive");
    lk(32'h1FFF_FFFF, "R1 global top");
    lk(32'h2000_0000, "R1 global high exclusive");

    // first-level refill
    fill(20'h80000);
    lk(32'h8000_0ABC, "R6 stack first lookup from L2");
    lk(32'h8000_0123, "R6 stack second lookup from micro-TLB");
    fill(20'h40300);
    lk(32'h4030_0000, "R5 heap from L2");
    lk(32'h4030_0010, "R5 heap never micro-TLB");

    // round-robin of stack micro-TLB
    for (int i = 1; i <= 4; i++) fill(20'h80000 + 20'(i));
    for (int i = 1; i <= 4; i++) lk({20'h80000 + 20'(i), 12'h0}, "R7 install");
    lk(32'h8000_0000, "R7 fifth install evicted first entry");
    lk(32'h8000_2000, "R7 third entry still present");

    // invalidation
    wr_bnd(2'd0, 32'h8000_0000);
    lk(32'h8000_2000, "R10 micro-TLB cleared by boundary write");
    lk(32'h8000_2000, "R10 refilled after clear");
    wr_bnd(2'd3, 32'h0000_0000);
    lk(32'h8000_2000, "R11 selector 3 ignored, entry kept");
    lk(32'h9000_0000, "R11 stack boundary unchanged");

    // miss path
    lk(32'h1000_5000, "R8 global double miss");
    fill(20'h10005);
    lk(32'h1000_5000, "R8 miss installed nothing");
    lk(32'h1000_5000, "R6 global micro-TLB hit");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k, c, pick;
      logic [VPN_W-1:0] v;
      k = $urandom_range(7);
      pick = $urandom_range(2);
      v = (pick == 0) ? 20'h80010 + 20'(k) :
          (pick == 1) ? 20'h10010 + 20'(k) : 20'h40400 + 20'(k);
      c = $urandom_range(99);
      if (c < 20) fill(v);
      else if (c < 23) wr_bnd(2'($urandom_range(3)), (pick == 0) ? 32'h8000_0000 :
                                                      (pick == 1) ? 32'h1000_0000 : 32'h2000_0000);
      else lk({v, 12'($urandom)}, "R1 R2 R5 R6 R7 R10 random");
    end

    // restore and final checks
    wr_bnd(2'd0, 32'h8000_0000);
    wr_bnd(2'd1, 32'h1000_0000);
    wr_bnd(2'd2, 32'h2000_0000);
    lk(32'h8001_0000, "R10 after rewrite");
    @(negedge clk);
    chk("R4 no response without request", !rsp_valid,
        $sformatf("v%0d", rsp_valid), "v0");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule